// File: doc/BRIEF.md
# DRAM Refresh Cycle Decoder

This block is the refresh front end of a 4-bit-wide DRAM array, modelled synchronously. It samples two active-low strobes (row strobe `ras_n` and column strobe `cas_n`) together with an external row address on every clock. Each falling edge of the row strobe is classified by the state of the column strobe around it. Column strobe high gives a row-strobe-only refresh of the externally addressed row. Column strobe already low from before the edge, without a read in progress, gives a column-before-row (CBR) refresh from an internal row counter. Column strobe held low since a read cycle, with the row strobe cycled, gives a hidden refresh from the internal counter while the read data stays driven.

For every classified edge the block emits a one-cycle `refresh_valid` pulse with the refreshed row index and a mode code. The internal counter moves only on CBR and hidden refreshes. Normal accesses and row-strobe-only cycles leave it alone. A data-output-enable flag shows when read data is driven. A scaled retention monitor splits time into fixed windows of `RETAIN_CYCLES` clocks. It latches a sticky error if any row went through a whole window without a refresh.

The strobes come from a memory controller that cannot be stalled, so there is no valid/ready handshake and no back-pressure. Every output is a plain registered signal, and a consumer must take each pulse in the cycle it appears.

Top module: `dram_refresh_decoder`

## Requirements
- R1: While and after reset, `refresh_valid`, `dq_oe` and `retention_err` are 0 and the internal row counter is 0, so the first CBR or hidden refresh after reset reports row 0.
- R2: A row-strobe fall sampled at clock edge t (`ras_n` 1 at t-1, 0 at t) with `cas_n` high at t raises `refresh_valid` for the cycle after edge t, with `refresh_mode` = 0 and `refresh_row` equal to `ext_row` sampled at t.
- R3: During a row-strobe-only refresh `dq_oe` stays 0, because no read is in progress.
- R4: A row-strobe fall with `cas_n` low, where the column strobe fell while `ras_n` was high or on the same sampled edge as the row strobe, is a CBR refresh: `refresh_mode` = 1, `refresh_row` is the internal counter, `ext_row` is ignored and `dq_oe` stays 0.
- R5: The internal counter increments by one after each CBR or hidden refresh and wraps from 2^ROW_BITS-1 to 0.
- R6: Row-strobe-only cycles and normal read accesses (column strobe falling while the row strobe is low, released without a hidden refresh) do not change the internal counter.
- R7: A column-strobe fall sampled while `ras_n` was low on both this edge and the previous one starts a read: `dq_oe` becomes 1 in the next cycle and stays 1 while `cas_n` is held low. A row-strobe fall during that hold is a hidden refresh: `refresh_mode` = 2 and `refresh_row` is the internal counter.
- R8: `dq_oe` returns to 0 in the cycle after `cas_n` is sampled high.
- R9: `refresh_valid` is high for exactly one cycle per row-strobe fall. Row-strobe rises and column-strobe edges produce no pulse.
- R10: Retention windows are consecutive runs of `RETAIN_CYCLES` clock edges, starting at the first edge after reset. At the last edge of a window, if any row had no refresh during that window, `retention_err` becomes 1 from the next cycle and stays 1 until reset.
- R11: A refresh whose row-strobe fall is sampled on the last edge of a window counts for that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| ext_row | input | ROW_BITS | Externally supplied row address |
| refresh_valid | output | 1 | One-cycle pulse per refreshed row |
| refresh_row | output | ROW_BITS | Index of the refreshed row, valid with the pulse |
| refresh_mode | output | 2 | 0 row-strobe-only, 1 CBR, 2 hidden |
| dq_oe | output | 1 | Read data is being driven |
| retention_err | output | 1 | Sticky retention deadline miss |

## Verification
The assertions assume that both strobes are synchronous to `clk` and settle between edges, and that `ext_row` is stable on the edge where the row strobe is seen falling. Under those assumptions each pulse is isolated, the mode code is legal, and the counter sequence is checkable from the outputs alone. The bench drives every input on the falling clock edge. It builds only complete strobe sequences (a refresh, a read with or without hidden refreshes) that always return both strobes high. It times the one boundary refresh by counting edges since reset, so the row-strobe fall lands on the last edge of a window.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    MODE_RAS_ONLY = 2'd0,
    MODE_CBR      = 2'd1,
    MODE_HIDDEN   = 2'd2
  } ref_mode_e;

endpackage

// File: rtl/dram_ref_classify.sv
module dram_ref_classify
  import dram_ref_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ras_n,
  input  logic      cas_n,
  output logic      ev,
  output ref_mode_e ev_mode,
  output logic      rd_active
);

  logic ras_q;
  logic cas_q;
  logic ras_fall;
  logic cas_fall;

  assign ras_fall = ras_q & ~ras_n;
  assign cas_fall = cas_q & ~cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
    end
  end

  // A read starts when the column strobe falls inside an open row cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
    end else if (cas_n) begin
      rd_active <= 1'b0;
    end else if (cas_fall && !ras_n && !ras_q) begin
      rd_active <= 1'b1;
    end
  end

  assign ev = ras_fall;

  always_comb begin
    if (cas_n) begin
      ev_mode = MODE_RAS_ONLY;
    end else if (rd_active) begin
      ev_mode = MODE_HIDDEN;
    end else begin
      ev_mode = MODE_CBR;
    end
  end

endmodule

// File: rtl/dram_ref_rowctr.sv
module dram_ref_rowctr #(
  parameter int ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output logic [ROW_BITS-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + ROW_BITS'(1);
    end
  end

endmodule

// File: rtl/dram_ref_retention.sv
module dram_ref_retention #(
  parameter int ROW_BITS      = 9,
  parameter int RETAIN_CYCLES = 2000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev,
  input  logic [ROW_BITS-1:0] ev_row,
  output logic                err
);

  localparam int ROWS  = 1 << ROW_BITS;
  localparam int WIN_W = (RETAIN_CYCLES > 2) ? $clog2(RETAIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(RETAIN_CYCLES - 1);

  logic [WIN_W-1:0] win_cnt;
  logic             win_end;
  logic [ROWS-1:0]  covered;
  logic             flag_q [ROWS];

  assign win_end = (win_cnt == WIN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (win_end) begin
      win_cnt <= '0;
    end else begin
      win_cnt <= win_cnt + WIN_W'(1);
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic hit;
    assign hit        = ev && (ev_row == ROW_BITS'(g));
    assign covered[g] = flag_q[g] | hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else if (win_end) begin
        flag_q[g] <= 1'b0;
      end else begin
        flag_q[g] <= covered[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else if (win_end && !(&covered)) begin
      err <= 1'b1;
    end
  end

endmodule

// File: rtl/dram_refresh_decoder.sv
module dram_refresh_decoder
  import dram_ref_pkg::*;
#(
  parameter int ROW_BITS      = 9,
  parameter int RETAIN_CYCLES = 2000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic [ROW_BITS-1:0] ext_row,
  output logic                refresh_valid,
  output logic [ROW_BITS-1:0] refresh_row,
  output logic [1:0]          refresh_mode,
  output logic                dq_oe,
  output logic                retention_err
);

  logic                ev;
  ref_mode_e           ev_mode;
  logic                rd_active;
  logic                ctr_step;
  logic [ROW_BITS-1:0] ctr_row;
  logic [ROW_BITS-1:0] sel_row;

  dram_ref_classify u_classify (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .ev        (ev),
    .ev_mode   (ev_mode),
    .rd_active (rd_active)
  );

  assign ctr_step = ev && (ev_mode != MODE_RAS_ONLY);
  assign sel_row  = (ev_mode == MODE_RAS_ONLY) ? ext_row : ctr_row;

  dram_ref_rowctr #(.ROW_BITS(ROW_BITS)) u_rowctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (ctr_step),
    .cnt   (ctr_row)
  );

  dram_ref_retention #(
    .ROW_BITS      (ROW_BITS),
    .RETAIN_CYCLES (RETAIN_CYCLES)
  ) u_retention (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .ev_row (sel_row),
    .err    (retention_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_valid <= 1'b0;
      refresh_row   <= '0;
      refresh_mode  <= 2'd0;
    end else begin
      refresh_valid <= ev;
      if (ev) begin
        refresh_row  <= sel_row;
        refresh_mode <= ev_mode;
      end
    end
  end

  assign dq_oe = rd_active;

endmodule

// File: rtl/dram_ref_checker.sv
module dram_ref_checker #(
  parameter int ROW_BITS = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ROW_BITS-1:0] ext_row,
  input logic                refresh_valid,
  input logic [ROW_BITS-1:0] refresh_row,
  input logic [1:0]          refresh_mode,
  input logic                dq_oe,
  input logic                retention_err
);

  logic                have_prev;
  logic [ROW_BITS-1:0] prev_ctr_row;
  logic [ROW_BITS-1:0] want_ctr_row;
  logic                ctr_pulse;

  assign ctr_pulse    = refresh_valid && (refresh_mode != 2'd0);
  assign want_ctr_row = have_prev ? (prev_ctr_row + ROW_BITS'(1)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev    <= 1'b0;
      prev_ctr_row <= '0;
    end else if (ctr_pulse) begin
      have_prev    <= 1'b1;
      prev_ctr_row <= refresh_row;
    end
  end

  assert_ras_only_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_valid && refresh_mode == 2'd0) |-> refresh_row == $past(ext_row));

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_valid |-> refresh_mode != 2'd3);

  assert_ras_only_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_valid && refresh_mode == 2'd0) |-> !dq_oe);

  assert_cbr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_valid && refresh_mode == 2'd1) |-> !dq_oe);

  assert_ctr_sequence_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_pulse |-> refresh_row == want_ctr_row);

  assert_hidden_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_valid && refresh_mode == 2'd2) |-> dq_oe);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_valid |=> !refresh_valid);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retention_err |=> retention_err);

endmodule

bind dram_refresh_decoder dram_ref_checker #(.ROW_BITS(ROW_BITS)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .ext_row       (ext_row),
  .refresh_valid (refresh_valid),
  .refresh_row   (refresh_row),
  .refresh_mode  (refresh_mode),
  .dq_oe         (dq_oe),
  .retention_err (retention_err)
);

// File: tb/dram_refresh_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_decoder_tb_top;

  localparam int RB  = 3;
  localparam int NR  = 1 << RB;
  localparam int RET = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ras_n = 1'b1;
  logic          cas_n = 1'b1;
  logic [RB-1:0] ext_row = '0;
  logic          refresh_valid;
  logic [RB-1:0] refresh_row;
  logic [1:0]    refresh_mode;
  logic          dq_oe;
  logic          retention_err;

  int            tests = 0;
  int            fails = 0;
  int            pk = -1;
  logic [RB-1:0] exp_cnt = '0;
  bit            seen [NR];
  bit            exp_err = 1'b0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  dram_refresh_decoder #(.ROW_BITS(RB), .RETAIN_CYCLES(RET)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .ext_row       (ext_row),
    .refresh_valid (refresh_valid),
    .refresh_row   (refresh_row),
    .refresh_mode  (refresh_mode),
    .dq_oe         (dq_oe),
    .retention_err (retention_err)
  );

  always @(posedge clk) if (rst_n) pk <= pk + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Retention model: windows of RET edges, pk is the index of the last edge.
  always @(negedge clk) begin
    if (rst_n && pk >= 0 && !done) begin
      if (refresh_valid) seen[refresh_row] = 1'b1;
      if (pk % RET == RET - 1) begin
        bit all_rows;
        all_rows = 1'b1;
        for (int i = 0; i < NR; i++) begin
          if (!seen[i]) all_rows = 1'b0;
          seen[i] = 1'b0;
        end
        if (!all_rows) exp_err = 1'b1;
        chk("R10 R11", "retention_err at window end", 32'(retention_err), 32'(exp_err));
      end else if (retention_err !== exp_err) begin
        chk("R10", "retention_err", 32'(retention_err), 32'(exp_err));
      end
    end
  end

  task automatic ras_only(input logic [RB-1:0] row);
    ext_row = row; cas_n = 1'b1; ras_n = 1'b0;
    @(negedge clk);
    chk("R2", "valid", 32'(refresh_valid), 1);
    chk("R2", "mode", 32'(refresh_mode), 0);
    chk("R2", "row", 32'(refresh_row), 32'(row));
    chk("R3", "dq_oe", 32'(dq_oe), 0);
    ext_row = ~row;
    @(negedge clk);
    chk("R9", "valid drop", 32'(refresh_valid), 0);
    ras_n = 1'b1;
    @(negedge clk);
    chk("R9", "no pulse on rise", 32'(refresh_valid), 0);
  endtask

  task automatic cbr(input bit same_edge);
    if (!same_edge) begin
      cas_n = 1'b0;
      @(negedge clk);
      chk("R9", "no pulse on cas fall", 32'(refresh_valid), 0);
      chk("R4", "dq_oe before ras", 32'(dq_oe), 0);
    end
    ext_row = exp_cnt + 3'd3;
    cas_n = 1'b0; ras_n = 1'b0;
    @(negedge clk);
    chk("R4", "valid", 32'(refresh_valid), 1);
    chk("R4", "mode", 32'(refresh_mode), 1);
    chk("R5", "counter row", 32'(refresh_row), 32'(exp_cnt));
    chk("R4", "dq_oe", 32'(dq_oe), 0);
    exp_cnt = exp_cnt + 1'b1;
    @(negedge clk);
    chk("R9", "valid drop", 32'(refresh_valid), 0);
    ras_n = 1'b1; cas_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_hidden(input logic [RB-1:0] row, input int n);
    ext_row = row; ras_n = 1'b0;
    @(negedge clk);
    chk("R2", "access row", 32'(refresh_row), 32'(row));
    cas_n = 1'b0;
    @(negedge clk);
    chk("R7", "dq_oe after read", 32'(dq_oe), 1);
    chk("R9", "no pulse on cas fall", 32'(refresh_valid), 0);
    for (int i = 0; i < n; i++) begin
      ras_n = 1'b1;
      @(negedge clk);
      chk("R7", "dq_oe held", 32'(dq_oe), 1);
      ras_n = 1'b0; ext_row = ~exp_cnt;
      @(negedge clk);
      chk("R7", "hidden valid", 32'(refresh_valid), 1);
      chk("R7", "hidden mode", 32'(refresh_mode), 2);
      chk("R5", "hidden row", 32'(refresh_row), 32'(exp_cnt));
      chk("R7", "dq_oe in hidden", 32'(dq_oe), 1);
      exp_cnt = exp_cnt + 1'b1;
    end
    ras_n = 1'b1;
    @(negedge clk);
    chk("R7", "dq_oe after ras rise", 32'(dq_oe), 1);
    chk("R9", "no pulse", 32'(refresh_valid), 0);
    cas_n = 1'b1;
    @(negedge clk);
    chk("R8", "dq_oe release", 32'(dq_oe), 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 32'(refresh_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid", 32'(refresh_valid), 0);
    chk("R1", "dq_oe", 32'(dq_oe), 0);
    chk("R1", "retention_err", 32'(retention_err), 0);

    // Window 0: every function, every row.
    for (int r = 0; r < NR; r++) ras_only(RB'(r));
    for (int k = 0; k < NR + 2; k++) cbr(k[0]);   // R5 wrap after NR steps
    ras_only(3'd5);                                // R6 between CBRs
    cbr(1'b0);
    read_hidden(3'd4, 0);                          // R6 normal read
    cbr(1'b0);
    read_hidden(3'd2, 3);
    read_hidden(3'd6, 1);
    cbr(1'b1);

    // Window 1: rows 0..NR-2 early, last row on the final edge (R11).
    while (pk < RET) @(negedge clk);
    for (int r = 0; r < NR - 1; r++) ras_only(RB'(r));
    while (pk != 2 * RET - 2) @(negedge clk);
    ext_row = RB'(NR - 1); ras_n = 1'b0;
    @(negedge clk);
    chk("R11", "boundary pulse", 32'(refresh_valid), 1);
    @(negedge clk);
    ras_n = 1'b1;

    // Window 2: idle, deadline missed.
    while (pk < 3 * RET + 2) @(negedge clk);
    chk("R10", "error raised", 32'(retention_err), 1);
    ras_only(3'd1);
    cbr(1'b0);
    chk("R10", "error sticky", 32'(retention_err), 1);
    finish_run();
  end

endmodule